// File: doc/BRIEF.md
# Timebase Capture, Compare and PWM Channel

This block is one channel of a counter array. It watches a shared free-running timebase count and does one of three jobs. It can latch the count when a chosen edge arrives on an external pin. It can raise an event flag when the count equals a stored value. It can drive a pulse-width output whose duty is set by that same stored value. One register pair, split into high and low halves, serves all three jobs.

A per-channel mode byte selects the job, the active capture edges and the event interrupt. The channel also keeps the timebase overflow flag. It produces one interrupt request that merges the event flag and the overflow flag, gated by a block enable and a global enable. The pin is resynchronized before edges are detected, so a pin change shows up in the register pair on the third clock edge after it is first sampled.

Top module: `cap_cmp_channel`

## Requirements
- R1: After reset, the mode byte, the register pair, both flags, `irq` and `pwm_out` are all zero.
- R2: A write to the mode byte stores bits 0 (event interrupt enable), 1 (PWM mode), 4 (falling-edge capture), 5 (rising-edge capture) and 6 (compare enable). Bits 2, 3 and 7 always read back as 0.
- R3: With bit 5 set, a rising edge on `cap_pin` loads the full count into the register pair. The pin passes through two flops and an edge stage. A pin level first sampled at clock edge k loads the count present at edge k+2.
- R4: With bit 4 set, a falling edge captures in the same way. An edge whose enable bit is clear captures nothing. With both bits set, either transition captures.
- R5: A capture sets the event flag. It takes priority over a software write to either half of the register pair in the same cycle.
- R6: With bit 6 set and bit 1 clear, a cycle in which the count equals the register pair sets the event flag at the next edge. Software writes to the pair are used from the next cycle on.
- R7: `flag_clr` clears the event flag. A capture or match in the same cycle wins, and the flag stays set.
- R8: With bit 1 set, `pwm_out` is 1 when the low half of the count is at or above the low half of the pair, and 0 below it. With bit 1 clear, `pwm_out` is 0.
- R9: In PWM mode, when the low half of the count is all ones, the low half of the pair is reloaded from the high half. This reload takes priority over a software write to the low half, but not over a capture.
- R10: `tb_ovf` sets the overflow flag. `ovf_clr` clears it, and `tb_ovf` wins when both are present.
- R11: `irq` = `global_irq_en` & `pca_irq_en` & ((event flag & mode bit 0) | (overflow flag & `ovf_irq_en`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte write data |
| cmp_hi_we | input | 1 | Write strobe, high half of the register pair |
| cmp_lo_we | input | 1 | Write strobe, low half of the register pair |
| cmp_wdata | input | CNT_W/2 | Write data for either half |
| flag_clr | input | 1 | Clear the event flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| pca_irq_en | input | 1 | Counter-array interrupt enable |
| global_irq_en | input | 1 | Global interrupt enable |
| tb_count | input | CNT_W | Shared timebase count |
| tb_ovf | input | 1 | Timebase overflow pulse |
| cap_pin | input | 1 | Asynchronous capture input |
| mode_q | output | 8 | Mode byte readback |
| cmp_q | output | CNT_W | Register pair readback |
| evt_flag | output | 1 | Capture/match event flag |
| ovf_flag | output | 1 | Timebase overflow flag |
| pwm_out | output | 1 | Pulse-width output |
| irq | output | 1 | Merged interrupt request |

## Verification
The bound checker checks on every cycle that a capture puts the previous cycle's count into the pair, that a match or overflow pulse leaves its flag set, and that a lone clear empties the event flag. It also checks that the PWM reload copies the high half, that `pwm_out` is quiet outside PWM mode, and that `irq` stays low without the global enable. Only the bench scenarios can show the three-edge capture latency, the per-edge masking, the capture-over-write priority and the exact duty across full low-byte periods. They check these against a reference model built from the requirements.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
   localparam int MB_IRQ  = 0;
   localparam int MB_PWM  = 1;
   localparam int MB_FALL = 4;
   localparam int MB_RISE = 5;
   localparam int MB_CMP  = 6;
   localparam logic [7:0] MODE_MASK = 8'h73;

   typedef struct packed {
      logic irq_en;
      logic pwm_en;
      logic fall_en;
      logic rise_en;
      logic cmp_en;
   } mode_t;

   function automatic mode_t decode_mode(input logic [7:0] m);
      mode_t d;
      d.irq_en  = m[MB_IRQ];
      d.pwm_en  = m[MB_PWM];
      d.fall_en = m[MB_FALL];
      d.rise_en = m[MB_RISE];
      d.cmp_en  = m[MB_CMP];
      return d;
   endfunction
endpackage

// File: rtl/cc_edge_sync.sv
`timescale 1ns/1ps
module cc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] sh;
   logic         prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[TOP-1:0], pin};
         prev <= sh[TOP];
      end
   end

   assign rise = sh[TOP] & ~prev;
   assign fall = ~sh[TOP] & prev;
endmodule

// File: rtl/cc_set_clr.sv
`timescale 1ns/1ps
module cc_set_clr (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/cc_cmp_pwm.sv
`timescale 1ns/1ps
module cc_cmp_pwm #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] ref_val,
   input  logic             cmp_en,
   input  logic             pwm_en,
   output logic             match,
   output logic             reload,
   output logic             pwm
);
   localparam int HALF = CNT_W / 2;

   logic [HALF-1:0] cnt_lo;
   logic [HALF-1:0] thr_lo;

   assign cnt_lo = count[HALF-1:0];
   assign thr_lo = ref_val[HALF-1:0];

   assign match  = cmp_en & ~pwm_en & (count == ref_val);
   assign reload = pwm_en & (&cnt_lo);
   assign pwm    = pwm_en & (cnt_lo >= thr_lo);
endmodule

// File: rtl/cap_cmp_channel.sv
`timescale 1ns/1ps
module cap_cmp_channel #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_we,
   input  logic [7:0]           mode_wdata,
   input  logic                 cmp_hi_we,
   input  logic                 cmp_lo_we,
   input  logic [CNT_W/2-1:0]   cmp_wdata,
   input  logic                 flag_clr,
   input  logic                 ovf_clr,
   input  logic                 ovf_irq_en,
   input  logic                 pca_irq_en,
   input  logic                 global_irq_en,
   input  logic [CNT_W-1:0]     tb_count,
   input  logic                 tb_ovf,
   input  logic                 cap_pin,
   output logic [7:0]           mode_q,
   output logic [CNT_W-1:0]     cmp_q,
   output logic                 evt_flag,
   output logic                 ovf_flag,
   output logic                 pwm_out,
   output logic                 irq
);
   import cc_pkg::*;

   localparam int HALF = CNT_W / 2;

   generate
      if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_w
         $error("cap_cmp_channel: CNT_W must be even and at least 4");
      end
   endgenerate

   logic [7:0]      mode_r;
   logic [HALF-1:0] hi_r;
   logic [HALF-1:0] lo_r;
   mode_t           md;
   logic            rise, fall;
   logic            cap_fire;
   logic            match_hit;
   logic            reload;

   assign md = decode_mode(mode_r);

   cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_pin),
      .rise (rise),
      .fall (fall)
   );

   assign cap_fire = (rise & md.rise_en) | (fall & md.fall_en);

   cc_cmp_pwm #(.CNT_W(CNT_W)) u_cmp (
      .count  (tb_count),
      .ref_val({hi_r, lo_r}),
      .cmp_en (md.cmp_en),
      .pwm_en (md.pwm_en),
      .match  (match_hit),
      .reload (reload),
      .pwm    (pwm_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_r <= '0;
      else if (mode_we) mode_r <= mode_wdata & MODE_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_r <= '0;
         lo_r <= '0;
      end else if (cap_fire) begin
         hi_r <= tb_count[CNT_W-1:HALF];
         lo_r <= tb_count[HALF-1:0];
      end else begin
         if (cmp_hi_we) hi_r <= cmp_wdata;
         if (reload)         lo_r <= hi_r;
         else if (cmp_lo_we) lo_r <= cmp_wdata;
      end
   end

   cc_set_clr u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (cap_fire | match_hit),
      .clr  (flag_clr),
      .q    (evt_flag)
   );

   cc_set_clr u_ovf (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (tb_ovf),
      .clr  (ovf_clr),
      .q    (ovf_flag)
   );

   assign mode_q = mode_r;
   assign cmp_q  = {hi_r, lo_r};
   assign irq    = global_irq_en & pca_irq_en &
                   ((evt_flag & md.irq_en) | (ovf_flag & ovf_irq_en));
endmodule

// File: rtl/cap_cmp_channel_chk.sv
`timescale 1ns/1ps
module cap_cmp_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] tb_count,
   input logic             tb_ovf,
   input logic             flag_clr,
   input logic             global_irq_en,
   input logic [7:0]       mode_q,
   input logic [CNT_W-1:0] cmp_q,
   input logic             evt_flag,
   input logic             ovf_flag,
   input logic             pwm_out,
   input logic             irq,
   input logic             cap_fire,
   input logic             match_hit
);
   localparam int HALF = CNT_W / 2;

   AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> (cmp_q == $past(tb_count)));  // R3
   AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> evt_flag);  // R5
   AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      match_hit |=> evt_flag);  // R6
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_fire && !match_hit) |=> !evt_flag);  // R7
   AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[1] |-> !pwm_out);  // R8
   AST_PWM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && (&tb_count[HALF-1:0]) && !cap_fire)
      |=> (cmp_q[HALF-1:0] == $past(cmp_q[CNT_W-1:HALF])));  // R9
   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tb_ovf |=> ovf_flag);  // R10
   AST_IRQ_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !global_irq_en |-> !irq);  // R11
endmodule

bind cap_cmp_channel cap_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tb_count     (tb_count),
   .tb_ovf       (tb_ovf),
   .flag_clr     (flag_clr),
   .global_irq_en(global_irq_en),
   .mode_q       (mode_q),
   .cmp_q        (cmp_q),
   .evt_flag     (evt_flag),
   .ovf_flag     (ovf_flag),
   .pwm_out      (pwm_out),
   .irq          (irq),
   .cap_fire     (cap_fire),
   .match_hit    (match_hit)
);

// File: tb/cap_cmp_channel_bench.sv
`timescale 1ns/1ps
module cap_cmp_channel_bench;
   localparam int W = 16;
   localparam int B = W / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_we = 1'b0;
   logic [7:0]   mode_wdata = '0;
   logic         cmp_hi_we = 1'b0, cmp_lo_we = 1'b0;
   logic [B-1:0] cmp_wdata = '0;
   logic         flag_clr = 1'b0, ovf_clr = 1'b0;
   logic         ovf_irq_en = 1'b0, pca_irq_en = 1'b0, global_irq_en = 1'b0;
   logic [W-1:0] tb_count = '0;
   logic         tb_ovf;
   logic         cap_pin = 1'b0;
   logic [7:0]   mode_q;
   logic [W-1:0] cmp_q;
   logic         evt_flag, ovf_flag, pwm_out, irq;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   assign tb_ovf = (tb_count == '1);

   cap_cmp_channel #(.CNT_W(W)) u_cap_cmp_channel (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .cmp_hi_we(cmp_hi_we), .cmp_lo_we(cmp_lo_we), .cmp_wdata(cmp_wdata),
      .flag_clr(flag_clr), .ovf_clr(ovf_clr), .ovf_irq_en(ovf_irq_en),
      .pca_irq_en(pca_irq_en), .global_irq_en(global_irq_en),
      .tb_count(tb_count), .tb_ovf(tb_ovf), .cap_pin(cap_pin),
      .mode_q(mode_q), .cmp_q(cmp_q), .evt_flag(evt_flag),
      .ovf_flag(ovf_flag), .pwm_out(pwm_out), .irq(irq)
   );

   // Reference model, built from the requirement text
   logic [7:0]   m_mode;
   logic [W-1:0] m_cmp;
   logic         m_evt, m_ovf, m_s1, m_s2, m_d;
   logic         e_cap, e_match, e_rel;
   logic [B-1:0] n_hi, n_lo;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = '0; m_cmp = '0; m_evt = 1'b0; m_ovf = 1'b0;
         m_s1 = 1'b0; m_s2 = 1'b0; m_d = 1'b0;
      end else begin
         e_cap   = (m_s2 & ~m_d & m_mode[5]) | (~m_s2 & m_d & m_mode[4]);
         e_match = m_mode[6] & ~m_mode[1] & (tb_count == m_cmp);
         e_rel   = m_mode[1] & (tb_count[B-1:0] == '1);
         n_hi = m_cmp[W-1:B];
         n_lo = m_cmp[B-1:0];
         if (e_cap) begin
            n_hi = tb_count[W-1:B];
            n_lo = tb_count[B-1:0];
         end else begin
            if (cmp_hi_we) n_hi = cmp_wdata;
            if (e_rel) n_lo = m_cmp[W-1:B];
            else if (cmp_lo_we) n_lo = cmp_wdata;
         end
         m_cmp = {n_hi, n_lo};
         if (e_cap | e_match) m_evt = 1'b1;
         else if (flag_clr)   m_evt = 1'b0;
         if (tb_ovf)          m_ovf = 1'b1;
         else if (ovf_clr)    m_ovf = 1'b0;
         if (mode_we) m_mode = mode_wdata & 8'h73;
         m_d  = m_s2;
         m_s2 = m_s1;
         m_s1 = cap_pin;
      end
   end

   function automatic logic exp_pwm(input logic [7:0] md, input logic [W-1:0] c,
                                    input logic [W-1:0] r);
      return md[1] & (c[B-1:0] >= r[B-1:0]);
   endfunction

   function automatic logic exp_irq(input logic [7:0] md, input logic ev,
                                    input logic ov);
      return global_irq_en & pca_irq_en & ((ev & md[0]) | (ov & ovf_irq_en));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2 mode", 32'(mode_q), 32'(m_mode));
      chk("R3 pair", 32'(cmp_q), 32'(m_cmp));
      chk("R6 evt", 32'(evt_flag), 32'(m_evt));
      chk("R10 ovf", 32'(ovf_flag), 32'(m_ovf));
      chk("R8 pwm", 32'(pwm_out), 32'(exp_pwm(m_mode, tb_count, m_cmp)));
      chk("R11 irq", 32'(irq), 32'(exp_irq(m_mode, m_evt, m_ovf)));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      if (rst_n) check_all();
      mode_we = 1'b0; cmp_hi_we = 1'b0; cmp_lo_we = 1'b0;
      flag_clr = 1'b0; ovf_clr = 1'b0;
      tb_count = tb_count + 1'b1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr_mode(input logic [7:0] v);
      mode_we = 1'b1; mode_wdata = v; tick();
   endtask

   task automatic wr_pair(input logic [W-1:0] v);
      cmp_hi_we = 1'b1; cmp_lo_we = 1'b0; cmp_wdata = v[W-1:B]; tick();
      cmp_lo_we = 1'b1; cmp_wdata = v[B-1:0]; tick();
   endtask

   task automatic clear_evt();
      flag_clr = 1'b1; tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nvec++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [W-1:0] snap;
      void'($urandom(32'd20240611));
      // R1: reset state
      ticks(3);
      chk("R1 mode", 32'(mode_q), 0); chk("R1 pair", 32'(cmp_q), 0);
      chk("R1 evt", 32'(evt_flag), 0); chk("R1 ovf", 32'(ovf_flag), 0);
      chk("R1 irq", 32'(irq), 0); chk("R1 pwm", 32'(pwm_out), 0);
      rst_n = 1'b1;
      tick();

      // R2: reserved bits read zero
      wr_mode(8'hFF);
      chk("R2 mask", 32'(mode_q), 32'h73);
      wr_mode(8'h20);
      clear_evt();

      // R3: rising edge only
      cap_pin = 1'b1; ticks(4);
      chk("R3 rise captures", 32'(evt_flag), 1);
      clear_evt();
      chk("R7 clear", 32'(evt_flag), 0);
      cap_pin = 1'b0; ticks(4);
      chk("R4 fall masked", 32'(evt_flag), 0);

      // R4: falling only, then both edges
      wr_mode(8'h10);
      cap_pin = 1'b1; ticks(4);
      chk("R4 rise masked", 32'(evt_flag), 0);
      cap_pin = 1'b0; ticks(4);
      chk("R4 fall captures", 32'(evt_flag), 1);
      clear_evt();
      wr_mode(8'h30);
      cap_pin = 1'b1; ticks(4);
      chk("R4 both rise", 32'(evt_flag), 1);
      clear_evt();
      cap_pin = 1'b0; ticks(4);
      chk("R4 both fall", 32'(evt_flag), 1);
      clear_evt();

      // R5: capture beats a same-cycle write
      wr_mode(8'h20);
      cap_pin = 1'b1; ticks(2);
      cmp_hi_we = 1'b1; cmp_lo_we = 1'b1; cmp_wdata = 8'hA5;
      snap = tb_count;
      tick();
      chk("R5 capture wins", 32'(cmp_q), 32'(snap));
      cap_pin = 1'b0; ticks(3);
      clear_evt();

      // R6: compare match
      wr_mode(8'h40);
      clear_evt();
      wr_pair(tb_count + 16'd12);
      ticks(6);
      chk("R6 no early match", 32'(evt_flag), 0);
      ticks(10);
      chk("R6 match", 32'(evt_flag), 1);
      clear_evt();

      // R8/R9: PWM over several low-byte periods
      wr_mode(8'h02);
      wr_pair(16'h4040);
      tb_count = 16'h1200;
      ticks(520);
      cmp_hi_we = 1'b1; cmp_wdata = 8'h80; tick();
      while (tb_count[B-1:0] != 8'h01) tick();
      chk("R9 reload", 32'(cmp_q[B-1:0]), 32'h80);
      ticks(300);

      // R10/R11: overflow and interrupt gating
      wr_mode(8'h01);
      ovf_irq_en = 1'b1; pca_irq_en = 1'b1; global_irq_en = 1'b1;
      tb_count = 16'hFFFD;
      ticks(4);
      chk("R10 ovf set", 32'(ovf_flag), 1);
      chk("R11 irq on", 32'(irq), 1);
      global_irq_en = 1'b0; tick();
      chk("R11 irq gated", 32'(irq), 0);
      ovf_clr = 1'b1; tick();
      chk("R10 ovf cleared", 32'(ovf_flag), 0);

      // Random phase
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(49) == 0) tb_count = W'($urandom);
         if ($urandom_range(39) == 0) begin
            mode_we = 1'b1; mode_wdata = 8'($urandom);
         end
         if ($urandom_range(29) == 0) begin
            cmp_hi_we = 1'b1; cmp_lo_we = 1'b1; cmp_wdata = 8'($urandom);
         end else if ($urandom_range(9) == 0) begin
            cmp_hi_we = $urandom_range(1) == 1; cmp_lo_we = ~cmp_hi_we;
            cmp_wdata = cmp_hi_we ? tb_count[W-1:B] : B'(tb_count[B-1:0] + 8'd4);
         end
         if ($urandom_range(5) == 0) cap_pin = ~cap_pin;
         flag_clr = $urandom_range(15) == 0;
         ovf_clr  = $urandom_range(15) == 0;
         if ($urandom_range(29) == 0) begin
            ovf_irq_en = 1'($urandom); pca_irq_en = 1'($urandom);
            global_irq_en = 1'($urandom);
         end
         tick();
      end
      finish_run();
   end
endmodule